// File: doc/BRIEF.md
# Horizontal Sobel Gradient with Clip or Wrap Output

This block takes a 3x3 neighbourhood of unsigned 8-bit pixels and computes the horizontal edge response: the left column, weighted 1-2-1 from top to bottom, minus the right column with the same weights. The centre column has weight zero. The result is an 8-bit value that leaves through a single output register one clock after the pixels are presented.

The signed difference is held at a width that covers every possible input, from -1020 to +1020, so it never overflows before the output stage. A mode input picks how that value is reduced to 8 bits. Clip mode limits it to the range 0..255. Wrap mode keeps its residue modulo 256. A line-buffer stage upstream supplies the window each cycle. Downstream logic chooses clip mode for display and wrap mode when it needs the low bits of the response.

Top module: `hgrad_sobel`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `grad_out` becomes 0 after that edge, whatever the pixel and mode inputs are.
- R2: `grad_out` after a rising edge reflects the pixel and mode inputs sampled at that edge, so the latency is one cycle.
- R3: In clip mode (`wrap_mode` = 0), a sum S = nw + 2*w + sw - ne - 2*e - se greater than 255 gives `grad_out` = 255.
- R4: In clip mode, a negative S gives `grad_out` = 0.
- R5: In clip mode, an S in 0..255 gives `grad_out` = S.
- R6: In wrap mode (`wrap_mode` = 1), `grad_out` = S mod 256, taken as the non-negative residue (for example, S = -1 gives 255).
- R7: The three centre-column pixels (`pix_n`, `pix_c`, `pix_s`) never change `grad_out`.
- R8: The extreme sums are exact. With the left column at 255 and the right at 0, S = +1020, which gives 255 when clipped and 252 when wrapped. With the columns swapped, S = -1020, which gives 0 when clipped and 4 when wrapped.
- R9: The middle row has weight 2 and the top and bottom rows have weight 1 in both side columns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wrap_mode | input | 1 | 0 = clip to 0..255, 1 = modulo 256 |
| pix_nw | input | 8 | Top row, left column |
| pix_n | input | 8 | Top row, centre column |
| pix_ne | input | 8 | Top row, right column |
| pix_w | input | 8 | Middle row, left column |
| pix_c | input | 8 | Middle row, centre column |
| pix_e | input | 8 | Middle row, right column |
| pix_sw | input | 8 | Bottom row, left column |
| pix_s | input | 8 | Bottom row, centre column |
| pix_se | input | 8 | Bottom row, right column |
| grad_out | output | 8 | Registered gradient result |

## Verification
The bench targets the edges of the clip window: S of -1, 0, 255 and 256. At these points an off-by-one comparison or a sign bit read as magnitude would return 255 for a negative sum, or the low byte for 256. It drives the ±1020 extremes in both modes, where an intermediate that is too narrow wraps to the wrong sign and clips the wrong way. It also varies the centre column with the side columns held fixed, which exposes a design that leaks the centre pixels into the sum. It swaps single-pixel stimuli between the middle and outer rows, which exposes wrong weights. A random run compared on every clock catches a missing or extra pipeline stage.

// File: rtl/hgrad_pkg.sv
package hgrad_pkg;

    localparam int PIX_W_DEF = 8;

    typedef enum logic {
        FOLD_CLIP = 1'b0,
        FOLD_WRAP = 1'b1
    } fold_mode_e;

    // Width of a 1-2-1 weighted column sum of unsigned pixels of width w
    function automatic int colsum_width(input int w);
        return w + 2;
    endfunction

    // Width of the signed difference of two column sums
    function automatic int diff_width(input int w);
        return w + 3;
    endfunction

endpackage

// File: rtl/hgrad_colsum.sv
module hgrad_colsum #(
    parameter int PIX_W = hgrad_pkg::PIX_W_DEF,
    localparam int CS_W = hgrad_pkg::colsum_width(PIX_W)
) (
    input  logic [PIX_W-1:0] top_px,
    input  logic [PIX_W-1:0] mid_px,
    input  logic [PIX_W-1:0] bot_px,
    output logic [CS_W-1:0]  col_sum
);
    always_comb begin
        col_sum = {2'b00, top_px} + {1'b0, mid_px, 1'b0} + {2'b00, bot_px};
    end
endmodule

// File: rtl/hgrad_fold.sv
module hgrad_fold #(
    parameter int PIX_W = hgrad_pkg::PIX_W_DEF,
    localparam int DF_W = hgrad_pkg::diff_width(PIX_W)
) (
    input  logic signed [DF_W-1:0] diff_in,
    input  hgrad_pkg::fold_mode_e  mode,
    output logic [PIX_W-1:0]       folded
);
    logic is_neg;
    logic is_big;

    always_comb begin
        is_neg = diff_in[DF_W-1];
        is_big = |diff_in[DF_W-2:PIX_W];
        if (mode == hgrad_pkg::FOLD_WRAP) begin
            folded = diff_in[PIX_W-1:0];
        end else if (is_neg) begin
            folded = '0;
        end else if (is_big) begin
            folded = '1;
        end else begin
            folded = diff_in[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/hgrad_sobel.sv
module hgrad_sobel #(
    parameter int PIX_W = hgrad_pkg::PIX_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap_mode,
    input  logic [PIX_W-1:0] pix_nw,
    input  logic [PIX_W-1:0] pix_n,
    input  logic [PIX_W-1:0] pix_ne,
    input  logic [PIX_W-1:0] pix_w,
    input  logic [PIX_W-1:0] pix_c,
    input  logic [PIX_W-1:0] pix_e,
    input  logic [PIX_W-1:0] pix_sw,
    input  logic [PIX_W-1:0] pix_s,
    input  logic [PIX_W-1:0] pix_se,
    output logic [PIX_W-1:0] grad_out
);
    localparam int CS_W = hgrad_pkg::colsum_width(PIX_W);
    localparam int DF_W = hgrad_pkg::diff_width(PIX_W);
    localparam int NSIDE = 2;

    // side 0 = left column (positive), side 1 = right column (negative)
    logic [PIX_W-1:0] side_px [NSIDE][3];
    logic [CS_W-1:0]  side_sum [NSIDE];
    logic signed [DF_W-1:0] diff;
    logic [PIX_W-1:0] folded;
    hgrad_pkg::fold_mode_e mode;

    // centre column carries zero weight and is not routed into the datapath
    logic unused_centre;
    assign unused_centre = ^{pix_n, pix_c, pix_s};

    always_comb begin
        side_px[0][0] = pix_nw;
        side_px[0][1] = pix_w;
        side_px[0][2] = pix_sw;
        side_px[1][0] = pix_ne;
        side_px[1][1] = pix_e;
        side_px[1][2] = pix_se;
        mode = wrap_mode ? hgrad_pkg::FOLD_WRAP : hgrad_pkg::FOLD_CLIP;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        hgrad_colsum #(.PIX_W(PIX_W)) u_col (
            .top_px (side_px[s][0]),
            .mid_px (side_px[s][1]),
            .bot_px (side_px[s][2]),
            .col_sum(side_sum[s])
        );
    end

    always_comb begin
        diff = $signed({1'b0, side_sum[0]}) - $signed({1'b0, side_sum[1]});
    end

    hgrad_fold #(.PIX_W(PIX_W)) u_fold (
        .diff_in(diff),
        .mode   (mode),
        .folded (folded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grad_out <= '0;
        end else begin
            grad_out <= folded;
        end
    end
endmodule

// File: rtl/hgrad_sobel_chk.sv
module hgrad_sobel_chk #(
    parameter int PIX_W = hgrad_pkg::PIX_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             wrap_mode,
    input logic [PIX_W-1:0] pix_nw,
    input logic [PIX_W-1:0] pix_ne,
    input logic [PIX_W-1:0] pix_w,
    input logic [PIX_W-1:0] pix_e,
    input logic [PIX_W-1:0] pix_sw,
    input logic [PIX_W-1:0] pix_se,
    input logic [PIX_W-1:0] grad_out
);
    logic left_zero, right_zero, left_high, only_nw;
    assign left_zero  = (pix_nw == '0) && (pix_w == '0) && (pix_sw == '0);
    assign right_zero = (pix_ne == '0) && (pix_e == '0) && (pix_se == '0);
    assign left_high  = pix_nw[PIX_W-1] && pix_w[PIX_W-1] && pix_sw[PIX_W-1];
    assign only_nw    = right_zero && (pix_w == '0) && (pix_sw == '0);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> grad_out == '0); // R1

    AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!wrap_mode && left_high && right_zero) |=> grad_out == '1); // R3

    AST_CLIP_LOW: assert property (@(posedge clk) disable iff (rst)
        (!wrap_mode && left_zero && !right_zero) |=> grad_out == '0); // R4

    AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        only_nw |=> grad_out == $past(pix_nw)); // R5

    AST_CENTRE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(wrap_mode) && $stable(pix_nw) && $stable(pix_w)
         && $stable(pix_sw) && $stable(pix_ne) && $stable(pix_e) && $stable(pix_se))
        |=> $stable(grad_out)); // R7
endmodule

bind hgrad_sobel hgrad_sobel_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/sim_hgrad_sobel.sv
`timescale 1ns/1ps
module sim_hgrad_sobel;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wrap_mode = 1'b0;
    logic [7:0] pix_nw = 0, pix_n = 0, pix_ne = 0, pix_w = 0, pix_c = 0,
                pix_e = 0, pix_sw = 0, pix_s = 0, pix_se = 0;
    logic [7:0] grad_out;

    int checks = 0;
    int errors = 0;
    int expected = 0;
    string exp_tag = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    hgrad_sobel u0 (.*);

    function automatic int model(int nw, int w, int sw, int ne, int e, int se, bit wr);
        int s;
        s = nw + 2 * w + sw - ne - 2 * e - se;
        if (wr) return ((s % 256) + 256) % 256;
        if (s > 255) return 255;
        if (s < 0) return 0;
        return s;
    endfunction

    // Check the result of the previous step, then drive the next one.
    task automatic step(int nw, int n, int ne, int w, int c, int e,
                        int sw, int s, int se, bit wr, bit r, string tag);
        @(negedge clk);
        checks++;
        if (grad_out !== expected[7:0]) begin
            errors++;
            $display("FAIL %s: grad_out=%0d expected=%0d", exp_tag, grad_out, expected);
        end
        pix_nw = nw[7:0]; pix_n = n[7:0]; pix_ne = ne[7:0];
        pix_w = w[7:0];   pix_c = c[7:0]; pix_e = e[7:0];
        pix_sw = sw[7:0]; pix_s = s[7:0]; pix_se = se[7:0];
        wrap_mode = wr; rst = r;
        expected = r ? 0 : model(nw, w, sw, ne, e, se, wr);
        exp_tag = tag;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: reset holds the output at 0 despite busy inputs
        step(255,9,0,255,9,0,255,9,0,0,1,"R1");
        step(255,9,0,255,9,0,255,9,0,1,1,"R1");
        // R5 in-range values and boundaries 0 and 255
        step(10,0,0,0,0,0,0,0,0,0,0,"R5");
        step(0,0,0,0,0,0,0,0,0,0,0,"R5");
        step(255,0,0,0,0,0,0,0,0,0,0,"R5");
        // R3: 256 and above clip to 255
        step(255,0,0,0,0,0,1,0,0,0,0,"R3");
        step(200,0,0,100,0,0,50,0,0,0,0,"R3");
        // R4: negative clips to 0
        step(0,0,1,0,0,0,0,0,0,0,0,"R4");
        step(5,0,0,0,0,3,0,0,0,0,0,"R4");
        // R6: wrap mode residues
        step(0,0,1,0,0,0,0,0,0,1,0,"R6");
        step(255,0,0,0,0,0,1,0,0,1,0,"R6");
        step(77,0,0,30,0,100,0,0,0,1,0,"R6");
        // R8: extremes
        step(255,0,0,255,0,0,255,0,0,0,0,"R8");
        step(255,0,0,255,0,0,255,0,0,1,0,"R8");
        step(0,0,255,0,0,255,0,0,255,0,0,"R8");
        step(0,0,255,0,0,255,0,0,255,1,0,"R8");
        // R9: row weights
        step(0,0,0,60,0,0,0,0,0,0,0,"R9");
        step(0,0,0,0,0,0,60,0,0,0,0,"R9");
        step(100,0,0,0,0,40,0,0,0,0,0,"R9");
        step(0,0,0,100,0,0,0,0,90,1,0,"R9");
        // R7: centre column varies, sides fixed
        step(40,0,10,20,0,5,30,0,7,0,0,"R7");
        step(40,255,10,20,255,5,30,255,7,0,0,"R7");
        step(40,17,10,20,200,5,30,3,7,0,0,"R7");
        step(40,17,10,20,200,5,30,3,7,1,0,"R7");
        // R1 again mid-run
        step(200,0,0,0,0,0,0,0,0,0,1,"R1");
        // R2: random stream compared every clock
        for (int i = 0; i < 300; i++) begin
            step($urandom_range(0,255), $urandom_range(0,255), $urandom_range(0,255),
                 $urandom_range(0,255), $urandom_range(0,255), $urandom_range(0,255),
                 $urandom_range(0,255), $urandom_range(0,255), $urandom_range(0,255),
                 1'($urandom_range(0,1)), 1'b0, "R2");
        end
        step(0,0,0,0,0,0,0,0,0,0,0,"R2");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule